// File: doc/BRIEF.md
# One-Shot Interrupt Gate with Tick Counter

This block collects a small set of level-sensitive interrupt request lines and delivers them to a CPU as a single interrupt request. Bit 0 is the serial receive request, bit 1 is the periodic timer tick, and bit 2, when present, is the audio request. Software sees the block through one 32-bit word. A read returns the current level of every request line and a free-running count of timer-tick cycles. A write arms or disarms delivery.

Delivery is one-shot. Each interrupt sent to the CPU disarms the block, so software must write the arm bit again before the next interrupt can be sent. Each arming write also starts a short hold-off counter. No interrupt is delivered until that counter has run out, which gives the CPU time to leave its handler before it can be interrupted again.

Top module: `oneshot_irq_ctrl`

## Requirements
- R1: Read bits 31:8 hold an unsigned count of the clock cycles in which request line 1 (timer tick) was high. Reset sets the count to zero.
- R2: The tick count wraps to zero after 2^TICK_W increments. TICK_W defaults to 24. The count occupies the top TICK_W bits of the word.
- R3: Read bits N_LINES-1:0 show each request line level as captured at the previous clock edge. Bit 0 is serial receive, bit 1 is timer, and bit 2 is audio (N_LINES defaults to 3). These bits are not latched and need no clear.
- R4: Every read bit between the pending field and the tick field reads zero.
- R5: A write (bus_sel=1, bus_wr=1) with bus_wdata bit 7 set arms delivery. While the block is armed, the hold-off has expired, at least one request line is high and no write is in progress, cpu_irq is high for exactly one cycle.
- R6: Delivery disarms the block. With the request lines held high, no second pulse follows until another arming write.
- R7: A write with bit 7 clear disarms the block. Other data bits have no effect.
- R8: An arming write loads a hold-off of 2^DLY_W-1 cycles (DLY_W defaults to 4). The earliest cpu_irq is seen 2^DLY_W clock edges after the edge that captured the write.
- R9: Synchronous reset (rst=1) clears the tick count, the arm state, the hold-off, the pending bits and cpu_irq.
- R10: A write with bus_sel low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | N_LINES | Level interrupt requests: bit 0 serial, bit 1 timer, bit 2 audio |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; bit 7 is the arm bit |
| bus_rdata | output | 32 | Tick count, zero gap, pending levels |
| cpu_irq | output | 1 | One-cycle interrupt request to the CPU |

## Verification
The hardest cases to reach involve timing between the arm state and the hold-off counter. One is a request that is already high when the block is armed. Another is a rearm write that lands on the same edge as a delivery would. A third is a reset that arrives while the block is armed and the hold-off has already expired. The stimulus holds request lines high across arming writes, measures the exact edge of the first pulse, and keeps lines high for long stretches to show that no second pulse appears. A reduced-width second instance covers the tick wrap, which a 24-bit count cannot reach in a short run.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  localparam int BUS_W   = 32;
  localparam int ARM_BIT = 7;
endpackage

// File: rtl/ictl_level_sampler.sv
module ictl_level_sampler #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_in,
  output logic [N-1:0] pend_q
);
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= req_in;
  end

  // R3: pending bits follow the line levels one edge later
  p_pend_follow_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pend_q == $past(req_in));
endmodule

// File: rtl/ictl_tick_counter.sv
module ictl_tick_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  output logic [W-1:0] tick_q
);
  always_ff @(posedge clk) begin
    if (rst)          tick_q <= '0;
    else if (tick_en) tick_q <= tick_q + 1'b1;
  end

  // R1: the count holds when the tick line is low
  p_tick_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(tick_q));
  // R2: the count steps by one and wraps modulo 2^W
  p_tick_step_r2: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> tick_q == W'($past(tick_q) + 1'b1));
endmodule

// File: rtl/ictl_arm_ctrl.sv
module ictl_arm_ctrl #(
  parameter int DLY_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic wr_arm,
  input  logic any_req,
  output logic cpu_irq
);
  localparam logic [DLY_W-1:0] HOLD_LOAD = {DLY_W{1'b1}};

  logic             arm_q;
  logic [DLY_W-1:0] dly_q;
  logic             fire;

  assign fire = arm_q && (dly_q == '0) && any_req && !wr_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q   <= 1'b0;
      dly_q   <= '0;
      cpu_irq <= 1'b0;
    end else begin
      cpu_irq <= fire;
      if (wr_hit) begin
        arm_q <= wr_arm;
        dly_q <= wr_arm ? HOLD_LOAD : '0;
      end else begin
        if (fire)         arm_q <= 1'b0;
        if (dly_q != '0)  dly_q <= dly_q - 1'b1;
      end
    end
  end

  // R5: a delivered request lasts a single cycle
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |=> !cpu_irq);
  // R6: delivery leaves the block disarmed
  p_disarm_fire_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> !arm_q);
  // R7: a write with the arm bit clear disarms
  p_disarm_write_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !wr_arm) |=> !arm_q);
  // R8: nothing is delivered while the hold-off runs
  p_holdoff_r8: assert property (@(posedge clk) disable iff (rst)
    (dly_q != '0) |=> !cpu_irq);
endmodule

// File: rtl/oneshot_irq_ctrl.sv
module oneshot_irq_ctrl
  import ictl_pkg::*;
#(
  parameter int N_LINES   = 3,
  parameter int TICK_W    = 24,
  parameter int DLY_W     = 4,
  parameter int TICK_LINE = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               cpu_irq
);
  localparam int GAP_W = BUS_W - TICK_W - N_LINES;

  logic [N_LINES-1:0] pend_q;
  logic [TICK_W-1:0]  tick_q;
  logic               wr_hit;
  logic               unused_wdata;

  assign wr_hit       = bus_sel && bus_wr;
  assign unused_wdata = ^{bus_wdata[BUS_W-1:ARM_BIT+1], bus_wdata[ARM_BIT-1:0]};

  ictl_level_sampler #(.N(N_LINES)) u_sample (
    .clk(clk), .rst(rst), .req_in(req_in), .pend_q(pend_q));

  ictl_tick_counter #(.W(TICK_W)) u_tick (
    .clk(clk), .rst(rst), .tick_en(req_in[TICK_LINE]), .tick_q(tick_q));

  ictl_arm_ctrl #(.DLY_W(DLY_W)) u_arm (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wr_arm(bus_wdata[ARM_BIT]),
    .any_req(|req_in), .cpu_irq(cpu_irq));

  generate
    if (GAP_W > 0) begin : g_gap
      assign bus_rdata = {tick_q, {GAP_W{1'b0}}, pend_q};
    end else begin : g_nogap
      assign bus_rdata = {tick_q, pend_q};
    end
  endgenerate

  // R4: the gap between fields always reads zero
  p_gap_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata >> N_LINES) == BUS_W'(tick_q) << (BUS_W - TICK_W - N_LINES));
  // R9: reset leaves the request output low
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> !cpu_irq);
endmodule

// File: tb/sim_oneshot_irq_ctrl.sv
module sim_oneshot_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  lines = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata1;
  logic        irq, irq1;

  int checks = 0, errors = 0, pulses = 0, cycles = 0;
  bit done = 0;

  // reference model state
  int m_tick, m1_tick, m_dly;
  bit m_arm, m_irq;
  logic [2:0] m_pend;

  always #4 clk = ~clk;

  oneshot_irq_ctrl u0 (.clk(clk), .rst(rst), .req_in(lines), .bus_sel(sel),
    .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .cpu_irq(irq));

  oneshot_irq_ctrl #(.N_LINES(2), .TICK_W(4)) u1 (.clk(clk), .rst(rst),
    .req_in(lines[1:0]), .bus_sel(sel), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata1), .cpu_irq(irq1));

  always @(posedge clk) begin
    bit w, f;
    cycles++;
    if (rst) begin
      m_tick = 0; m1_tick = 0; m_pend = '0; m_arm = 0; m_dly = 0; m_irq = 0;
    end else begin
      w = sel && wr;
      f = m_arm && m_dly == 0 && lines != 0 && !w;
      m_irq = f;
      if (w) begin
        m_arm = wdata[7];
        m_dly = wdata[7] ? 15 : 0;
      end else begin
        if (f) m_arm = 0;
        if (m_dly != 0) m_dly--;
      end
      m_pend = lines;
      if (lines[1]) begin
        m_tick = (m_tick + 1) % (1 << 24);
        m1_tick = (m1_tick + 1) % 16;
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1 tick field", rdata[31:8], m_tick);
    chk("R3 pending", rdata[2:0], m_pend);
    chk("R4 gap", rdata[7:3], 0);
    chk("R5 cpu_irq", irq, m_irq);
    chk("R2 narrow tick", rdata1[31:28], m1_tick);
    chk("R4 narrow gap", rdata1[27:2], 0);
    if (irq) pulses++;
  endtask

  task automatic cyc(logic [2:0] l, logic s, logic w, logic [31:0] d);
    lines = l; sel = s; wr = w; wdata = d;
    @(negedge clk);
    compare();
  endtask

  always @(posedge clk) if (cycles > 150000 && !done) begin
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    lines = 3'b111;
    @(negedge clk);
    rst = 1'b0; lines = '0;
    @(negedge clk);
    // R9: reset state
    chk("R9 reset rdata", rdata, 0);
    chk("R9 reset irq", irq, 0);

    // R1/R3: varied line patterns, nothing armed
    for (int i = 0; i < 40; i++) cyc(3'(i * 5 + i / 3), 0, 0, 0);
    chk("R5 no pulse when unarmed", pulses, 0);

    // R5: arm with lines low, then raise audio line
    cyc(0, 1, 1, 32'h0000_0080);
    for (int i = 0; i < 30; i++) cyc(0, 0, 0, 0);
    pulses = 0;
    for (int i = 0; i < 5; i++) cyc(3'b100, 0, 0, 0);
    chk("R5 one pulse", pulses, 1);

    // R6: held request, no second pulse
    pulses = 0;
    for (int i = 0; i < 50; i++) cyc(3'b101, 0, 0, 0);
    chk("R6 no repeat", pulses, 0);

    // R8: arm with a request already high, measure first pulse
    cyc(3'b001, 1, 1, 32'hFFFF_FF80);
    k = 0;
    for (int i = 1; i <= 40 && k == 0; i++) begin
      cyc(3'b001, 0, 0, 0);
      if (irq) k = i;
    end
    chk("R8 holdoff edges", k, 16);

    // R5: rearm write on the delivery edge wins and restarts hold-off
    cyc(3'b001, 1, 1, 32'h80);
    for (int i = 0; i < 15; i++) cyc(3'b000, 0, 0, 0);
    pulses = 0;
    cyc(3'b010, 1, 1, 32'h80);
    chk("R5 write blocks delivery", pulses, 0);
    for (int i = 0; i < 20; i++) cyc(3'b010, 0, 0, 0);
    chk("R5 delivery after rearm", pulses, 1);

    // R7: disarm with other bits set
    cyc(0, 1, 1, 32'h0000_00FF);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0);
    cyc(0, 1, 1, 32'hFFFF_FF7F);
    pulses = 0;
    for (int i = 0; i < 40; i++) cyc(3'b111, 0, 0, 0);
    chk("R7 disarmed", pulses, 0);

    // R10: write without select is ignored
    cyc(3'b111, 0, 1, 32'h80);
    for (int i = 0; i < 40; i++) cyc(3'b111, 0, 0, 0);
    chk("R10 unselected write", pulses, 0);

    // R2: long timer run wraps the narrow counter
    for (int i = 0; i < 37; i++) cyc(3'b010, 0, 0, 0);
    chk("R2 wrap value", rdata1[31:28], m1_tick);

    // R9: reset while armed and expired
    cyc(0, 1, 1, 32'h80);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0);
    rst = 1'b1;
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    rst = 1'b0;
    chk("R9 tick cleared", rdata[31:8], 0);
    pulses = 0;
    for (int i = 0; i < 40; i++) cyc(3'b011, 0, 0, 0);
    chk("R9 arm cleared", pulses, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule